// File: doc/BRIEF.md
# Two-Digit Free-Running Random Display

This block makes a two-digit pseudo-random number. Each digit comes from its own counter, and each counter advances at its own unrelated rate. When the operator stops the run, both counters freeze together, and the frozen pair is the result. The tens digit is an octal counter covering 0 to 7. The units digit is a decade counter covering 0 to 9. The number shown therefore lies between 00 and 79.

Each rate source is a slow, asynchronous level input. A two-flop synchroniser and a rising-edge detector turn each one into a single-cycle advance tick. A small run/hold state machine gates both ticks with the shared run control, in the same way an AND gate would suppress a clock. The counters use the gated ticks as clock enables, so the whole block runs on one clock. Each digit feeds a seven-segment decoder with active-high outputs. The states are ST_HOLD and ST_RUN. The transition START moves ST_HOLD to ST_RUN when the run input is high. The transition STOP moves ST_RUN to ST_HOLD when the run input is low. The gate itself uses the live run input, so a stop takes effect in the same cycle it is asserted.

Top module: `rnd_display`

## Requirements
- R1: A synchronous reset clears both digits to 0, and both displays then show the glyph for 0 (0x3F).
- R2: Each rising edge of the tens rate input, while running, advances the tens digit by one. The tens digit wraps from 7 to 0.
- R3: Each rising edge of the units rate input, while running, advances the units digit by one. The units digit wraps from 9 to 0 and never holds a value above 9.
- R4: A rate input held high for many cycles advances its digit only once.
- R5: An edge on one rate input never changes the other digit.
- R6: While the run input is low, ticks are ignored. This includes a tick that arrives in the same cycle the run input falls. The digits are unchanged on the next cycle.
- R7: A rate input that goes high before clock edge k shows its new digit value after edge k+2. The two edges before that one leave the digit unchanged.
- R8: The segment outputs are 7 bits, active high. Bit 6 is segment g, down to bit 0, which is segment a. The glyphs are 0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F, 9:0x6F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | 1 = counters free-run, 0 = hold |
| tens_rate_i | input | 1 | Asynchronous rate source for the tens digit |
| units_rate_i | input | 1 | Asynchronous rate source for the units digit |
| tens_val_o | output | 3 | Current tens digit |
| units_val_o | output | 4 | Current units digit |
| tens_seg_o | output | 7 | Tens seven-segment pattern {g,f,e,d,c,b,a} |
| units_seg_o | output | 7 | Units seven-segment pattern {g,f,e,d,c,b,a} |

## Verification
The assertions check on every cycle that:
- reset clears the counters;
- a synchronised tick lasts exactly one cycle;
- the units digit stays decimal and wraps to 0 after 9;
- a low run input leaves both digits stable on the following cycle;
- a valid digit never decodes to a blank display.

Only the bench scenarios can show the rest: the three-edge latency from a rate edge, a long high level advancing only once, independence of the two digits, the exact glyph patterns, and a tick swallowed when run drops in exactly its cycle.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    localparam int SEG_W = 7;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Active-high glyphs, bit order {g,f,e,d,c,b,a}; blank for non-digits
    function automatic logic [SEG_W-1:0] glyph(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        unique case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rnd_tick_sync.sv
module rnd_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic tick_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick_o = sync_q[SYNC_STAGES-1] & ~last_q;

    // R4: an edge yields a single-cycle tick
    a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rnd_digit_counter.sv
module rnd_digit_counter #(
    parameter int MODULUS = 10,
    parameter int WIDTH   = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] cnt_q;

    // Out-of-range states also fold back to zero on the next advance
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv_i)
            cnt_q <= (cnt_q >= LAST) ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R1: reset clears the digit
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> cnt_o == '0);
    // R2, R3: last value wraps to zero
    a_r2_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cnt_o == LAST) |=> cnt_o == '0);
    // R6: no advance, no change
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(cnt_o));
    // R3: value stays inside the radix
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= LAST);

endmodule

// File: rtl/rnd_seg_decoder.sv
module rnd_seg_decoder
    import rnd_pkg::*;
#(
    parameter int DIGIT_W   = 4,
    parameter int MAX_DIGIT = 9
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [SEG_W-1:0]   seg_o
);
    always_comb begin
        seg_o = glyph(4'(digit_i));
        if (int'(digit_i) > MAX_DIGIT)
            seg_o = '0;
    end

    // R8: a legal digit never decodes to a blank display
    always_comb begin
        if (int'(digit_i) <= MAX_DIGIT)
            a_r8_seg_nonblank: assert (seg_o != '0);
    end

endmodule

// File: rtl/rnd_display.sv
module rnd_display
    import rnd_pkg::*;
#(
    parameter int TENS_MOD    = 8,
    parameter int UNITS_MOD   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run_i,
    input  logic                        tens_rate_i,
    input  logic                        units_rate_i,
    output logic [$clog2(TENS_MOD)-1:0]  tens_val_o,
    output logic [$clog2(UNITS_MOD)-1:0] units_val_o,
    output logic [SEG_W-1:0]            tens_seg_o,
    output logic [SEG_W-1:0]            units_seg_o
);
    localparam int TENS_W  = $clog2(TENS_MOD);
    localparam int UNITS_W = $clog2(UNITS_MOD);

    run_state_t state_q, state_d;
    logic       tens_tick, units_tick;
    logic       tens_adv, units_adv;

    rnd_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) tens_sync_i (
        .clk(clk), .rst(rst), .async_i(tens_rate_i), .tick_o(tens_tick));
    rnd_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) units_sync_i (
        .clk(clk), .rst(rst), .async_i(units_rate_i), .tick_o(units_tick));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    // Transitions START / STOP and the gated advance outputs
    always_comb begin
        state_d   = state_q;
        tens_adv  = 1'b0;
        units_adv = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (run_i) begin
                    state_d   = ST_RUN;
                    tens_adv  = tens_tick;
                    units_adv = units_tick;
                end
            end
            ST_RUN: begin
                if (!run_i) state_d = ST_HOLD;
                else begin
                    tens_adv  = tens_tick;
                    units_adv = units_tick;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    rnd_digit_counter #(.MODULUS(TENS_MOD), .WIDTH(TENS_W)) tens_cnt_i (
        .clk(clk), .rst(rst), .adv_i(tens_adv), .cnt_o(tens_val_o));
    rnd_digit_counter #(.MODULUS(UNITS_MOD), .WIDTH(UNITS_W)) units_cnt_i (
        .clk(clk), .rst(rst), .adv_i(units_adv), .cnt_o(units_val_o));

    rnd_seg_decoder #(.DIGIT_W(TENS_W), .MAX_DIGIT(TENS_MOD - 1)) tens_dec_i (
        .digit_i(tens_val_o), .seg_o(tens_seg_o));
    rnd_seg_decoder #(.DIGIT_W(UNITS_W), .MAX_DIGIT(UNITS_MOD - 1)) units_dec_i (
        .digit_i(units_val_o), .seg_o(units_seg_o));

    // R6: a low run input freezes both digits for the next cycle
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ($stable(tens_val_o) && $stable(units_val_o)));
    // R6: after STOP the machine sits in ST_HOLD
    a_r6_stop_state: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !run_i) |=> state_q == ST_HOLD);

endmodule

// File: tb/rnd_display_tb.sv
module rnd_display_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 1'b0;
    logic       tens_rate_i = 1'b0;
    logic       units_rate_i = 1'b0;
    logic [2:0] tens_val_o;
    logic [3:0] units_val_o;
    logic [6:0] tens_seg_o;
    logic [6:0] units_seg_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rnd_display dut_i (
        .clk(clk), .rst(rst), .run_i(run_i),
        .tens_rate_i(tens_rate_i), .units_rate_i(units_rate_i),
        .tens_val_o(tens_val_o), .units_val_o(units_val_o),
        .tens_seg_o(tens_seg_o), .units_seg_o(units_seg_o));

    function automatic logic [6:0] ref_seg(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_digits(input string req, input int t, input int u);
        check(req, tens_val_o, t);
        check(req, units_val_o, u);
        check({req, " R8 tens seg"}, tens_seg_o, ref_seg(t));
        check({req, " R8 units seg"}, units_seg_o, ref_seg(u));
    endtask

    // One rising edge on the selected rate inputs, then let the pipeline settle
    task automatic pulse(input bit r, input bit t, input bit u);
        @(negedge clk);
        run_i = r; tens_rate_i = t; units_rate_i = u;
        repeat (3) @(negedge clk);
        tens_rate_i = 1'b0; units_rate_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // {run, tens pulse, units pulse, expected tens[2:0], expected units[3:0]}
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b1, 3'd1, 4'd1},
        {1'b1, 1'b0, 1'b1, 3'd1, 4'd2},  // R5
        {1'b0, 1'b1, 1'b1, 3'd1, 4'd2},  // R6
        {1'b1, 1'b1, 1'b0, 3'd2, 4'd2},  // R5
        {1'b1, 1'b1, 1'b1, 3'd3, 4'd3},
        {1'b0, 1'b0, 1'b1, 3'd3, 4'd3},  // R6
        {1'b1, 1'b1, 1'b1, 3'd4, 4'd4},
        {1'b1, 1'b0, 1'b0, 3'd4, 4'd4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_digits("R1 reset", 0, 0);

        for (int i = 0; i < 8; i++) begin
            pulse(VEC[i][9], VEC[i][8], VEC[i][7]);
            check_digits("R2 R3 R5 R6 vector", int'(VEC[i][6:4]), int'(VEC[i][3:0]));
        end

        // R7 latency: unchanged after two edges, updated after the third
        @(negedge clk);
        run_i = 1'b1; units_rate_i = 1'b1;
        @(negedge clk); check("R7 edge1", units_val_o, 4);
        @(negedge clk); check("R7 edge2", units_val_o, 4);
        @(negedge clk); check("R7 edge3", units_val_o, 5);
        // R4: keep the level high for a long time
        repeat (20) @(negedge clk);
        check("R4 held level", units_val_o, 5);
        units_rate_i = 1'b0;
        repeat (3) @(negedge clk);

        // R3 wrap 9 -> 0
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 1'b1);
        check_digits("R3 at nine", 4, 9);
        pulse(1'b1, 1'b0, 1'b1);
        check_digits("R3 wrap", 4, 0);

        // R2 wrap 7 -> 0
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, 1'b0);
        check_digits("R2 at seven", 7, 0);
        pulse(1'b1, 1'b1, 1'b0);
        check_digits("R2 wrap", 0, 0);

        // R6: run drops exactly in the tick cycle
        @(negedge clk);
        run_i = 1'b1; units_rate_i = 1'b1; tens_rate_i = 1'b1;
        repeat (2) @(negedge clk);
        run_i = 1'b0;
        @(negedge clk);
        check_digits("R6 same-cycle tick", 0, 0);
        run_i = 1'b1;
        repeat (4) @(negedge clk);
        tens_rate_i = 1'b0; units_rate_i = 1'b0;
        repeat (3) @(negedge clk);
        check_digits("R6 tick stays lost", 0, 0);

        // R1: synchronous reset during a run
        pulse(1'b1, 1'b1, 1'b1);
        pulse(1'b1, 1'b1, 1'b1);
        check_digits("R1 pre-reset", 2, 2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_digits("R1 mid-run reset", 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule